// File: doc/BRIEF.md
# Cell Delineation Loss Integrator

This block filters the raw cell delineation state into a stable loss-of-cell-delineation (LCD) status. The hunting logic upstream reports, on every clock, whether delineation currently sits in SYNC or has fallen out of it. A short dropout must not disturb the status. The status changes only after the opposite condition has persisted, so both directions have the same hysteresis.

A free-running prescaler divides the system clock and produces one sampling tick every `DIV` clocks. The default is 16383. On each tick a persistence counter checks whether the condition that would change the present status still holds. The counter restarts whenever the streak breaks. When the streak reaches the programmed period, the status flips. On the same clock edge the block emits a one-cycle interrupt pulse, provided the enable bit allows it.

All pins are plain control and status signals. No data stream passes through this block, so it has no valid/ready handshake.

Top module: `lcd_integrator`

## Requirements
- R1: While `rst_n` is low, and on the first clock after its release, `lcd` is 1 (loss) and `lcd_irq` is 0. The prescaler and the persistence counter both start from zero.
- R2: With `lcd` = 1, `lcd` falls to 0 at the end of the tick cycle on which `in_sync` (1 = SYNC) has been seen high on P consecutive ticks. P is the effective period. It does not fall earlier.
- R3: With `lcd` = 0, `lcd` rises to 1 at the end of the tick cycle on which `in_sync` has been seen low on P consecutive ticks. It does not rise earlier.
- R4: A tick on which `in_sync` does not match the condition needed to change `lcd` clears the persistence count. A broken streak must therefore restart from zero.
- R5: Each change of `lcd` in either direction is accompanied, on the same clock edge, by a pulse on `lcd_irq` exactly one clock long. This holds while `irq_en` = 1 on the tick cycle that causes the change.
- R6: When `irq_en` = 0 on the tick cycle that causes a change, `lcd` still changes but `lcd_irq` stays 0.
- R7: The effective period P equals `period`. The value 0 is treated as 1. All values up to 2^PERIOD_W-1 are honoured.
- R8: `in_sync` is sampled only on prescaler ticks, which fall on the last clock of every `DIV`-clock window after reset. Its value on all other clocks has no effect on `lcd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sync | input | 1 | Delineation state: 1 = SYNC, 0 = out of delineation |
| period | input | PERIOD_W | Integration period in prescaler ticks (0 acts as 1) |
| irq_en | input | 1 | Interrupt enable: 1 allows the change pulse |
| lcd | output | 1 | Filtered loss-of-cell-delineation status, 1 = loss |
| lcd_irq | output | 1 | One-clock pulse on each status change when enabled |

## Verification
The bench builds the block with `DIV` = 5 and `PERIOD_W` = 4. A tick therefore arrives every five clocks, and the full period range of 0 to 15 can be crossed within a few hundred cycles. These values bring a full-length integration, period 0 and period 1, broken streaks and masked changes within reach. They also allow patterns in which `in_sync` is driven to the opposite value on every non-tick clock, which exercises the sampling rule. A behavioural model in the bench predicts `lcd` and `lcd_irq` on every clock.

// File: rtl/lcdi_pkg.sv
package lcdi_pkg;
  // Effective integration length: a programmed 0 behaves as a single tick.
  function automatic int unsigned eff_len(input int unsigned p);
    return (p == 0) ? 1 : p;
  endfunction
endpackage

// File: rtl/lcdi_prescaler.sv
module lcdi_prescaler #(
  parameter int unsigned DIV = 16383
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  generate
    if (DIV <= 1) begin : g_passthru
      assign tick = 1'b1;
    end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);

      // R8: ticks are isolated, one per window
      a_r8_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
      a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    end
  endgenerate
endmodule

// File: rtl/lcdi_persist.sv
module lcdi_persist #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                in_sync,
  input  logic [PERIOD_W-1:0] period,
  output logic                lcd,
  output logic                flip
);
  import lcdi_pkg::*;

  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W:0]   cnt_inc;
  logic [PERIOD_W:0]   limit;
  logic                opposite;

  // condition that would move the status away from its present value
  assign opposite = lcd ? in_sync : !in_sync;
  assign cnt_inc  = {1'b0, cnt} + 1'b1;
  assign limit    = (PERIOD_W + 1)'(eff_len(32'(period)));
  assign flip     = tick && opposite && (cnt_inc >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcd <= 1'b1;
      cnt <= '0;
    end else if (tick) begin
      if (flip) begin
        lcd <= !lcd;
        cnt <= '0;
      end else if (opposite) begin
        cnt <= cnt_inc[PERIOD_W-1:0];
      end else begin
        cnt <= '0;
      end
    end
  end

  // R8: status and count move only on tick edges
  a_r8_lcd_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lcd));
  a_r8_cnt_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R3: a rise needs an out-of-delineation sample on the previous tick
  a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd) |-> $past(tick && !in_sync));
  // R2: a fall needs a SYNC sample on the previous tick
  a_r2_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd) |-> $past(tick && in_sync));
  // R4: a mismatching tick leaves the count at zero
  a_r4_streak_break: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !opposite) |=> (cnt == '0));
endmodule

// File: rtl/lcdi_irq.sv
module lcdi_irq #(
  parameter int unsigned DIV = 16383
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  input  logic irq_en,
  input  logic lcd,
  output logic lcd_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) lcd_irq <= 1'b0;
    else        lcd_irq <= flip && irq_en;
  end

  // R5: every status change is paired with a pulse when enabled
  a_r5_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd != $past(lcd)) |-> (lcd_irq == $past(irq_en)));
  // R6: no pulse while the enable was low
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_irq |-> $past(irq_en));
  // R5: pulses accompany changes only
  a_r5_pulse_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_irq |-> (lcd != $past(lcd)));

  generate
    if (DIV > 1) begin : g_single
      a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_irq |=> !lcd_irq);
    end
  endgenerate
endmodule

// File: rtl/lcd_integrator.sv
module lcd_integrator #(
  parameter int unsigned DIV      = 16383,
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_sync,
  input  logic [PERIOD_W-1:0] period,
  input  logic                irq_en,
  output logic                lcd,
  output logic                lcd_irq
);
  logic tick;
  logic flip;

  lcdi_prescaler #(.DIV(DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  lcdi_persist #(.PERIOD_W(PERIOD_W)) u_per (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .in_sync (in_sync),
    .period  (period),
    .lcd     (lcd),
    .flip    (flip)
  );

  lcdi_irq #(.DIV(DIV)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flip    (flip),
    .irq_en  (irq_en),
    .lcd     (lcd),
    .lcd_irq (lcd_irq)
  );

  // R1: reset value of the status
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (lcd && !lcd_irq));
endmodule

// File: tb/tb_lcd_integrator.sv
module tb_lcd_integrator;
  localparam int CLK_NS = 10;
  localparam int DIV    = 5;
  localparam int PW     = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_sync = 1'b0;
  logic [PW-1:0] period = '0;
  logic          irq_en = 1'b0;
  logic          lcd;
  logic          lcd_irq;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 0;

  // behavioural reference state
  int m_pre = 0;
  int m_run = 0;
  bit m_lcd = 1;
  bit m_irq = 0;

  always #(CLK_NS/2) clk = ~clk;

  lcd_integrator #(.DIV(DIV), .PERIOD_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .period(period),
    .irq_en(irq_en), .lcd(lcd), .lcd_irq(lcd_irq)
  );

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, predict the coming edge, compare at next negedge
  task automatic cyc(input bit s);
    bit tk;
    bit nirq;
    int need;
    in_sync = s;
    tk   = (m_pre == DIV - 1);
    nirq = 0;
    need = (period == 0) ? 1 : int'(period);
    if (tk) begin
      if (m_lcd ? s : !s) begin
        m_run++;
        if (m_run >= need) begin
          m_lcd = !m_lcd;
          m_run = 0;
          nirq  = irq_en;
        end
      end else begin
        m_run = 0;
      end
    end
    m_pre = tk ? 0 : m_pre + 1;
    m_irq = nirq;
    @(negedge clk);
    check(lcd, m_lcd, "R2/R3/R4 lcd vs model");
    check(lcd_irq, m_irq, "R5/R6 irq vs model");
    if (lcd_irq) pulses++;
  endtask

  // n ticks; value at tick clocks is at_tick, at all other clocks off_tick
  task automatic ticks(input int n, input bit at_tick, input bit off_tick);
    for (int i = 0; i < n * DIV; i++)
      cyc((m_pre == DIV - 1) ? at_tick : off_tick);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset
    repeat (3) @(negedge clk);
    check(lcd, 1'b1, "R1 lcd in reset");
    check(lcd_irq, 1'b0, "R1 irq in reset");
    rst_n = 1'b1;
    period = 4'd3;
    irq_en = 1'b1;
    cyc(1'b1);  // first clock out of reset; pre count now 1
    check(lcd, 1'b1, "R1 lcd after release");
    ticks(1, 1'b0, 1'b0); // realign: next tick breaks streak, count zero
    // R2: clear after 3 SYNC ticks, not before
    pulses = 0;
    ticks(2, 1'b1, 1'b1);
    check(lcd, 1'b1, "R2 not early");
    ticks(1, 1'b1, 1'b1);
    check(lcd, 1'b0, "R2 cleared");
    check(pulses == 1, 1'b1, "R5 one pulse on clear");
    // R4: broken streak restarts
    ticks(2, 1'b0, 1'b0);
    ticks(1, 1'b1, 1'b1);
    ticks(2, 1'b0, 1'b0);
    check(lcd, 1'b0, "R4 streak restarted");
    // R3: third consecutive out tick declares loss
    ticks(1, 1'b0, 1'b0);
    check(lcd, 1'b1, "R3 declared");
    check(pulses == 2, 1'b1, "R5 pulse on declare");
    // R8: only tick samples count
    ticks(3, 1'b1, 1'b0);
    check(lcd, 1'b0, "R8 off-tick lows ignored");
    ticks(3, 1'b0, 1'b1);
    check(lcd, 1'b1, "R8 off-tick highs ignored");
    // R6: masked changes
    irq_en = 1'b0;
    pulses = 0;
    ticks(3, 1'b1, 1'b1);
    check(lcd, 1'b0, "R6 status still changes");
    ticks(3, 1'b0, 1'b0);
    check(pulses == 0, 1'b1, "R6 no pulse while masked");
    // R7: period 1 and period 0
    irq_en = 1'b1;
    period = 4'd1;
    ticks(1, 1'b1, 1'b1);
    check(lcd, 1'b0, "R7 period 1");
    period = 4'd0;
    ticks(1, 1'b0, 1'b0);
    check(lcd, 1'b1, "R7 period 0 acts as 1");
    // R7: maximum period
    period = 4'd15;
    ticks(14, 1'b1, 1'b1);
    check(lcd, 1'b1, "R7 max period not early");
    ticks(1, 1'b1, 1'b1);
    check(lcd, 1'b0, "R7 max period reached");
    ticks(2, 1'b1, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule